// File: doc/BRIEF.md
# Configuration Mechanism One Responder

This block answers the classic two-port scheme that a host uses to reach configuration space. A 32-bit address register sits at I/O port 0xCF8 and can be read back. A four-byte data window at ports 0xCFC to 0xCFF then reads or writes the configuration word selected by that register. Each access moves 1, 2 or 4 bytes. Each registered device owns a table of 64 configuration words, and the tables start at zero.

On the way in, writes follow the rules that make base address register (BAR) probing work with fixed 4 KiB windows. An all-ones write to a BAR slot turns into the size mask, or into zero when the slot is not implemented. Implemented I/O BARs always keep their type bit set. The expansion ROM base is read-only. Reads that target a missing bus, function or device return all ones. The number of devices, the BAR count of each device and the I/O or memory kind of each BAR are parameters.

Top module: `cfg_mech1_resp`

## Requirements
- R1: A write of size 4 bytes (size_i = 2 or 3) to port 0xCF8 loads the address register. A read of port 0xCF8 returns the whole register. The register is 0 after reset, and writes of 1 or 2 bytes to that port leave it unchanged.
- R2: Each read request (req_i high, we_i low) produces rvalid_o high with rdata_o on the following cycle only. rvalid_o is low in every other cycle.
- R3: While bit 31 of the address register is 0, a data-window read returns 0xFFFFFFFF and a data-window write changes nothing.
- R4: The address register fields are bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword index = bits 7:2. A target is absent when the bus is nonzero, the function is nonzero, or the device is not below DEV_CNT. Reads of an absent target return 0xFFFFFFFF and writes to it are ignored.
- R5: The window offset is port_i minus 0xCFC. Reads depend on size_i:
  - size_i = 0 (1 byte) returns bits [8*offset+7 : 8*offset] of the word, zero-extended.
  - size_i = 1 (2 bytes) returns bits 15:0 when the offset is 0 and bits 31:16 otherwise.
  - size_i of 2 or 3 (4 bytes) returns the whole word.
- R6: A data-window write replaces the low 1, 2 or 4 bytes of the selected word with the low bytes of wdata_i. The other bytes are kept.
- R7: The effective offset is the dword index times 4 plus the window offset. When it lies in 0x10 to 0x24 and wdata_i is 0xFFFFFFFF, the value stored is 0xFFFFF000 if BAR index (offset/4 - 4) is implemented and 0 otherwise.
- R8: A write whose effective offset selects an implemented I/O BAR is stored with bit 0 set to 1.
- R9: A write whose effective offset is exactly 0x30 is discarded.
- R10: Reads of any port other than 0xCF8 and 0xCFC to 0xCFF return 0xFFFFFFFF, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| port_i | input | 16 | I/O port address |
| size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |

## Verification
Writes take effect at the clock edge that samples the request, so a read issued on the next cycle already sees the new state. A read result is registered and is due exactly one edge after its request. The bench drives each request on a falling edge and holds it for one cycle. It then checks rvalid_o and rdata_o on the falling edge after the sampling edge, which is half a cycle clear of any update. The reference tables in the bench are updated as each write is issued, so every readback is compared with state settled at that point.

// File: rtl/cfg_m1_pkg.sv
package cfg_m1_pkg;
  localparam logic [15:0] ADDR_PORT = 16'h0CF8;
  localparam logic [15:0] DATA_PORT = 16'h0CFC;
  localparam int unsigned WORDS     = 64;
  localparam int unsigned MAX_BARS  = 6;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [31:0] BAR_MASK  = 32'hFFFF_F000;
  localparam logic [7:0]  BAR_LO    = 8'h10;
  localparam logic [7:0]  BAR_HI    = 8'h24;
  localparam logic [7:0]  ROM_OFF   = 8'h30;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_addr_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int unsigned DEV_CNT = 3
) (
  input  logic [31:0]           addr_i,
  output cfg_m1_pkg::cfg_addr_t fld_o,
  output logic                  present_o
);
  always_comb begin
    fld_o.en  = addr_i[31];
    fld_o.bus = addr_i[23:16];
    fld_o.dev = addr_i[15:11];
    fld_o.fn  = addr_i[10:8];
    fld_o.dw  = addr_i[7:2];
  end

  assign present_o = (fld_o.bus == 8'd0) && (fld_o.fn == 3'd0) &&
                     (32'(fld_o.dev) < DEV_CNT);
endmodule

// File: rtl/cfg_wr_fix.sv
module cfg_wr_fix (
  input  logic [7:0]  eff_off_i,
  input  logic [31:0] wdata_i,
  input  logic [2:0]  bar_cnt_i,
  input  logic [5:0]  bar_io_i,
  output logic [31:0] data_o,
  output logic        drop_o
);
  import cfg_m1_pkg::*;

  logic       in_bar;
  logic [5:0] bar_idx;
  logic       impl;

  assign in_bar  = (eff_off_i >= BAR_LO) && (eff_off_i <= BAR_HI);
  assign bar_idx = eff_off_i[7:2] - 6'd4;
  assign impl    = in_bar && (bar_idx < {3'd0, bar_cnt_i});
  assign drop_o  = (eff_off_i == ROM_OFF);

  always_comb begin
    data_o = wdata_i;
    if (in_bar && wdata_i == ALL_ONES) data_o = impl ? BAR_MASK : 32'd0;
    if (impl && bar_io_i[bar_idx[2:0]]) data_o[0] = 1'b1;
  end
endmodule

// File: rtl/cfg_table.sv
module cfg_table #(
  parameter int unsigned DEV_CNT = 3,
  localparam int unsigned DW     = (DEV_CNT > 1) ? $clog2(DEV_CNT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdev_i,
  input  logic [5:0]    widx_i,
  input  logic [3:0]    wbe_i,
  input  logic [31:0]   wdata_i,
  input  logic [DW-1:0] rdev_i,
  input  logic [5:0]    ridx_i,
  output logic [31:0]   rword_o
);
  logic [31:0] mem_q [DEV_CNT][cfg_m1_pkg::WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < int'(DEV_CNT); d++)
        for (int w = 0; w < int'(cfg_m1_pkg::WORDS); w++) mem_q[d][w] <= 32'd0;
    end else if (we_i) begin
      for (int b = 0; b < 4; b++)
        if (wbe_i[b]) mem_q[wdev_i][widx_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rword_o = mem_q[rdev_i][ridx_i];
endmodule

// File: rtl/cfg_mech1_resp.sv
module cfg_mech1_resp #(
  parameter int unsigned        DEV_CNT = 3,
  parameter logic [DEV_CNT*3-1:0] BAR_CNT = {3'd1, 3'd2, 3'd0},
  parameter logic [DEV_CNT*6-1:0] BAR_IO  = {6'b000001, 6'b000001, 6'b000000},
  localparam int unsigned       DW      = (DEV_CNT > 1) ? $clog2(DEV_CNT) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] port_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic        rvalid_o,
  output logic [31:0] rdata_o
);
  import cfg_m1_pkg::*;

  logic [31:0] addr_q;
  cfg_addr_t   fld;
  logic        present;
  logic        hit_addr, hit_data;
  logic [1:0]  ofs;
  logic [7:0]  eff_off;
  logic [2:0]  sel_cnt;
  logic [5:0]  sel_io;
  logic [31:0] fix_data, word;
  logic        drop, tbl_we;
  logic [3:0]  be;
  logic [DW-1:0] dev_idx;

  assign hit_addr = (port_i == ADDR_PORT);
  assign hit_data = (port_i[15:2] == DATA_PORT[15:2]);
  assign ofs      = port_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= 32'd0;
    else if (req_i && we_i && hit_addr && size_i[1]) addr_q <= wdata_i;
  end

  cfg_addr_decode #(.DEV_CNT(DEV_CNT)) u_dec (
    .addr_i(addr_q), .fld_o(fld), .present_o(present));

  assign dev_idx = fld.dev[DW-1:0];
  assign eff_off = {fld.dw, 2'b00} | {6'd0, ofs};

  always_comb begin
    sel_cnt = 3'd0;
    sel_io  = 6'd0;
    for (int d = 0; d < int'(DEV_CNT); d++)
      if (32'(fld.dev) == d) begin
        sel_cnt = BAR_CNT[3*d +: 3];
        sel_io  = BAR_IO[6*d +: 6];
      end
  end

  cfg_wr_fix u_fix (
    .eff_off_i(eff_off), .wdata_i(wdata_i), .bar_cnt_i(sel_cnt),
    .bar_io_i(sel_io), .data_o(fix_data), .drop_o(drop));

  always_comb begin
    unique case (size_i)
      2'd0:    be = 4'b0001;
      2'd1:    be = 4'b0011;
      default: be = 4'b1111;
    endcase
  end

  assign tbl_we = req_i && we_i && hit_data && fld.en && present && !drop;

  cfg_table #(.DEV_CNT(DEV_CNT)) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(tbl_we), .wdev_i(dev_idx),
    .widx_i(fld.dw), .wbe_i(be), .wdata_i(fix_data), .rdev_i(dev_idx),
    .ridx_i(fld.dw), .rword_o(word));

  logic [31:0] rd_next;
  always_comb begin
    rd_next = ALL_ONES;
    if (hit_addr) rd_next = addr_q;
    else if (hit_data && fld.en && present) begin
      unique case (size_i)
        2'd0:    rd_next = {24'd0, 8'(word >> {ofs, 3'b000})};
        2'd1:    rd_next = {16'd0, (ofs == 2'd0) ? word[15:0] : word[31:16]};
        default: rd_next = word;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= 32'd0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_next;
    end
  end

  // R2
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  // R2
  no_spur_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  // R1
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && hit_addr && size_i[1]) |=> (addr_q == $past(wdata_i)));
  // R3
  wr_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we |-> addr_q[31]);
  // R9
  rom_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we |-> (eff_off != ROM_OFF));
endmodule

// File: tb/cfg_mech1_resp_tb.sv
module cfg_mech1_resp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] port = 16'd0;
  logic [1:0]  size = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic        rvalid;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  logic [31:0] m_addr;
  logic [31:0] m_tbl [3][64];
  int unsigned bar_cnt [3] = '{0, 2, 1};
  logic [5:0]  bar_io  [3] = '{6'b0, 6'b1, 6'b1};

  always #2 clk = ~clk;

  cfg_mech1_resp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .port_i(port),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata));

  function automatic logic present_f();
    return m_addr[23:16] == 0 && m_addr[10:8] == 0 && m_addr[15:11] < 3;
  endfunction

  function automatic logic [31:0] exp_rd(logic [15:0] p, logic [1:0] s);
    logic [31:0] w;
    logic [1:0]  o;
    if (p == 16'h0CF8) return m_addr;
    if (p[15:2] != 14'h033F || !m_addr[31] || !present_f()) return 32'hFFFFFFFF;
    w = m_tbl[m_addr[15:11]][m_addr[7:2]];
    o = p[1:0];
    if (s == 0) return (w >> (8 * o)) & 32'hFF;
    if (s == 1) return (o == 0) ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
    return w;
  endfunction

  task automatic model_wr(logic [15:0] p, logic [1:0] s, logic [31:0] d);
    logic [7:0] eff;
    int idx, dv;
    logic impl;
    if (p == 16'h0CF8) begin
      if (s[1]) m_addr = d;
      return;
    end
    if (p[15:2] != 14'h033F || !m_addr[31] || !present_f()) return;
    dv  = int'(m_addr[15:11]);
    eff = {m_addr[7:2], 2'b00} + {6'd0, p[1:0]};
    idx = int'(eff) / 4 - 4;
    impl = (eff >= 8'h10 && eff <= 8'h24) && idx < int'(bar_cnt[dv]);
    if (eff >= 8'h10 && eff <= 8'h24 && d == 32'hFFFFFFFF) d = impl ? 32'hFFFFF000 : 32'h0;
    if (impl && bar_io[dv][idx]) d[0] = 1'b1;
    if (eff == 8'h30) return;
    for (int b = 0; b < 4; b++)
      if (b < (s == 0 ? 1 : s == 1 ? 2 : 4))
        m_tbl[dv][m_addr[7:2]][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic wr(logic [15:0] p, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; port = p; size = s; wdata = d;
    model_wr(p, s, d);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [15:0] p, logic [1:0] s, string tag);
    logic [31:0] e;
    @(negedge clk);
    req = 1; we = 0; port = p; size = s;
    e = exp_rd(p, s);
    @(negedge clk);
    req = 0;
    checks++;
    if (!rvalid || rdata !== e) begin
      errors++;
      $display("FAIL %s port=%h size=%0d actual=%h/%b expected=%h/1",
               tag, p, s, rdata, rvalid, e);
    end
  endtask

  function automatic logic [31:0] mk_addr(logic en, int bus, int dev, int fn, int dw);
    return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(dw), 2'b00};
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    m_addr = 0;
    for (int d = 0; d < 3; d++) for (int w = 0; w < 64; w++) m_tbl[d][w] = 0;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (rvalid !== 0) begin errors++; $display("FAIL R2 reset rvalid actual=%b expected=0", rvalid); end
    rd(16'h0CF8, 2, "R1 reset addr");
    wr(16'h0CF8, 0, 32'h12);
    rd(16'h0CF8, 2, "R1 narrow write ignored");
    wr(16'h0CF8, 2, mk_addr(0, 0, 1, 0, 1));
    rd(16'h0CF8, 2, "R1 addr readback");
    rd(16'h0CFC, 2, "R3 disabled read");
    wr(16'h0CFC, 2, 32'hCAFEBABE);
    wr(16'h0CF8, 2, mk_addr(1, 0, 1, 0, 1));
    rd(16'h0CFC, 2, "R3 disabled write ignored");
    wr(16'h0CF8, 2, mk_addr(1, 0, 1, 0, 4));
    wr(16'h0CFC, 2, 32'hFFFFFFFF);
    rd(16'h0CFC, 2, "R7 R8 io bar size");
    wr(16'h0CFC, 2, 32'h00001234);
    rd(16'h0CFC, 2, "R8 io bit forced");
    wr(16'h0CF8, 2, mk_addr(1, 0, 1, 0, 5));
    wr(16'h0CFC, 2, 32'hFFFFFFFF);
    rd(16'h0CFC, 2, "R7 mem bar size");
    wr(16'h0CF8, 2, mk_addr(1, 0, 1, 0, 6));
    wr(16'h0CFC, 2, 32'hFFFFFFFF);
    rd(16'h0CFC, 2, "R7 unimplemented bar");
    wr(16'h0CF8, 2, mk_addr(1, 0, 2, 0, 12));
    wr(16'h0CFC, 2, 32'h55AA55AA);
    rd(16'h0CFC, 2, "R9 rom discard");
    wr(16'h0CF8, 2, mk_addr(1, 0, 2, 0, 3));
    wr(16'h0CFC, 2, 32'hA1B2C3D4);
    wr(16'h0CFE, 0, 32'h000000EE);
    rd(16'h0CFC, 2, "R6 byte write low lane");
    rd(16'h0CFD, 0, "R5 byte read ofs1");
    rd(16'h0CFE, 1, "R5 half read upper");
    rd(16'h0CFC, 1, "R5 half read lower");
    wr(16'h0CF8, 2, mk_addr(1, 1, 0, 0, 3));
    rd(16'h0CFC, 2, "R4 bus nonzero");
    wr(16'h0CF8, 2, mk_addr(1, 0, 0, 2, 3));
    rd(16'h0CFC, 2, "R4 func nonzero");
    wr(16'h0CF8, 2, mk_addr(1, 0, 3, 0, 3));
    wr(16'h0CFC, 2, 32'h1);
    rd(16'h0CFC, 2, "R4 absent device");
    wr(16'h0D00, 2, 32'h0);
    rd(16'h0CF8, 2, "R10 other port write ignored");
    rd(16'h0080, 2, "R10 other port read");
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      logic [15:0] p = 16'h0CFC + 16'($urandom_range(0, 3));
      logic [1:0]  s = 2'($urandom_range(0, 3));
      logic [31:0] d = ($urandom_range(0, 3) == 0) ? 32'hFFFFFFFF : $urandom;
      if (k == 0)
        wr(16'h0CF8, 2, mk_addr($urandom_range(0, 7) != 0, ($urandom_range(0, 7) == 0) ? 2 : 0,
                                $urandom_range(0, 3), ($urandom_range(0, 7) == 0) ? 1 : 0,
                                ($urandom_range(0, 1) == 1) ? $urandom_range(4, 9) : $urandom_range(0, 63)));
      else if (k < 5) wr(p, s, d);
      else rd(p, s, "R5 R6 R7 R8 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule